// File: doc/BRIEF.md
# Dual-Channel Audio DMA Register Controller

This block is the register and sequencing core of a two-direction audio DMA engine. It has one capture channel, which moves data from the codec into memory, and one playback channel, which moves data from memory to the codec. Software sees a 48-byte word-addressed window. The window holds one combined control/status word. For each channel it also holds a current address, a current count, a next address and a next count. The memory bus master reports each transferred word on a one-cycle strobe. The block then advances the channel's address and count and hands the current address back to the master.

Each channel is double-buffered. Writing the next count arms the queued buffer, and a dirty flag shows that it is armed. When the current buffer runs out, the queued buffer is chained in. If nothing is queued, the channel stops and reports an underrun. The event flags are write-1-to-clear and share the control/status word with plain read/write control bits. Software must therefore write 0 to the flags it wants to keep when it updates control bits. A single interrupt output combines the flags that are enabled.

Top module: `audio_dma_regs`

## Requirements
- R1: After the synchronous reset, every register location reads 0 and `irq` is 0.
- R2: A word write at a 4-aligned byte offset stores the value, and a read returns it one cycle later. Capture uses offsets 16, 20, 24 and 28 for current address, current count, next address and next count. Playback uses offsets 32, 36, 40 and 44 for the same four registers. Offsets 4, 8 and 12, offsets of 48 or more, and unaligned addresses read 0 and ignore writes.
- R3: The control bits at offset 0 read back as written. They are bit 19 global interrupt enable, bits 18, 17 and 16 playback, capture and error interrupt enables, bit 12 playback underrun interrupt enable, bit 8 capture underrun interrupt enable, bits 7 and 6 playback and capture pause, bit 5 codec reset (driven on `codec_rst`), and bits 3 and 2 playback and capture run.
- R4: When a channel is running (run bit set, pause clear), each of its transfer strobes adds 4 to its current address and subtracts 1 from its current count. `cap_addr` and `play_addr` show the current addresses.
- R5: Writing a channel's next count sets that channel's dirty flag. The flag is bit 10 for capture and bit 13 for playback, and it holds until the next buffer is consumed.
- R6: A strobe that finds a count of 1 or less while the dirty flag is set loads the next address and count into the current registers. It also clears the dirty flag and sets the channel flag: bit 21 for capture, bit 22 for playback.
- R7: The same strobe with the dirty flag clear advances the address, sets the count to 0 and clears the run bit. For playback it also sets pipe-empty status bit 14 and interrupt flag bit 15. For capture it sets data-dropped bit 11 and interrupt flag bit 9. Bits 14 and 11 are sticky.
- R8: A capture strobe while the capture run bit and the capture pause bit are both clear sets data-dropped bit 11.
- R9: While a channel's pause bit is set, its strobes change no register. Clearing the pause bit lets the next strobe continue from the held address and count, with no reload.
- R10: Writing 1 to flag bit 22, 21, 20, 15 or 9 clears it, and writing 0 leaves it unchanged.
- R11: A pulse on `err_evt` sets error flag bit 20.
- R12: Bit 23 reads as the OR of the enabled flags. The pairs are 22/18, 21/17, 20/16, 15/12 and 9/8. `irq` is registered and equals bit 19 AND bit 23 one cycle later.
- R13: Writing 1 to bit 0 clears every register and flag. For the following cycle offset 0 reads exactly 1, and after that bit 0 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, registered, for the address of the previous cycle |
| cap_xfer | input | 1 | Capture word transferred strobe |
| play_xfer | input | 1 | Playback word transferred strobe |
| err_evt | input | 1 | Error event strobe |
| cap_addr | output | DATA_W | Capture current address |
| play_addr | output | DATA_W | Playback current address |
| cap_run | output | 1 | Capture running and not paused |
| play_run | output | 1 | Playback running and not paused |
| codec_rst | output | 1 | Codec reset control |
| irq | output | 1 | Interrupt request |

## Verification
The transfer path is driven with single strobes while running, with strobes while paused and with strobes while idle. Comparing these shows whether a strobe advances, holds or only records a drop. The count-exhaustion case is tried once with a queued buffer and once without, so a swap between the chaining and stopping outcomes shows up in the flag and run bits. The flag word is written with 0s and then with 1s over pending flags, to show that the clear is write-1 only. Enables are switched one at a time, so each flag/enable pair and the global gate can be seen separately on `irq`.

// File: rtl/adma_pkg.sv
package adma_pkg;
  // word indices inside the register window
  localparam int W_CSR   = 0;
  localparam int W_CHAN0 = 4;
  localparam int W_SPAN  = 4;
  localparam int NUM_CH  = 2;
  localparam int CH_CAP  = 0;
  localparam int CH_PLAY = 1;
  // per-channel word order
  localparam int S_CUR_ADDR = 0;
  localparam int S_CUR_CNT  = 1;
  localparam int S_NXT_ADDR = 2;
  localparam int S_NXT_CNT  = 3;

  // control/status bit positions
  localparam int B_SUM   = 23;
  localparam int B_PFLAG = 22;
  localparam int B_CFLAG = 21;
  localparam int B_EFLAG = 20;
  localparam int B_GIE   = 19;
  localparam int B_PIE   = 18;
  localparam int B_CIE   = 17;
  localparam int B_EIE   = 16;
  localparam int B_PUFL  = 15;
  localparam int B_PEMPT = 14;
  localparam int B_PDIRT = 13;
  localparam int B_PUIE  = 12;
  localparam int B_CDROP = 11;
  localparam int B_CDIRT = 10;
  localparam int B_CUFL  = 9;
  localparam int B_CUIE  = 8;
  localparam int B_PPAUS = 7;
  localparam int B_CPAUS = 6;
  localparam int B_CODEC = 5;
  localparam int B_PRUN  = 3;
  localparam int B_CRUN  = 2;
  localparam int B_SRST  = 0;

  localparam logic [31:0] CTRL_MASK =
      (32'd1 << B_GIE) | (32'd1 << B_PIE) | (32'd1 << B_CIE) | (32'd1 << B_EIE) |
      (32'd1 << B_PUIE) | (32'd1 << B_CUIE) | (32'd1 << B_PPAUS) |
      (32'd1 << B_CPAUS) | (32'd1 << B_CODEC) | (32'd1 << B_PRUN) |
      (32'd1 << B_CRUN);
endpackage

// File: rtl/adma_channel.sv
module adma_channel #(
  parameter int DATA_W    = 32,
  parameter int STEP      = 4,
  parameter bit DROP_IDLE = 1'b0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              go,
  input  logic              pause,
  input  logic              xfer,
  input  logic [3:0]        wr_sel,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] cur_addr,
  output logic [DATA_W-1:0] cur_cnt,
  output logic [DATA_W-1:0] nxt_addr,
  output logic [DATA_W-1:0] nxt_cnt,
  output logic              dirty,
  output logic              reload_ev,
  output logic              stop_ev,
  output logic              drop_ev
);
  import adma_pkg::*;

  localparam logic [DATA_W-1:0] STEP_V = DATA_W'(STEP);
  localparam logic [DATA_W-1:0] ONE_V  = DATA_W'(1);

  logic strobe;
  logic terminal;

  always_comb begin
    strobe    = xfer && go && !pause && !clr;
    terminal  = strobe && (cur_cnt <= ONE_V);
    reload_ev = terminal && dirty;
    stop_ev   = terminal && !dirty;
    drop_ev   = DROP_IDLE && xfer && !go && !pause && !clr;
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cur_addr <= '0;
      cur_cnt  <= '0;
      nxt_addr <= '0;
      nxt_cnt  <= '0;
      dirty    <= 1'b0;
    end else begin
      if (wr_sel[S_CUR_ADDR])   cur_addr <= wdata;
      else if (reload_ev)       cur_addr <= nxt_addr;
      else if (strobe)          cur_addr <= cur_addr + STEP_V;

      if (wr_sel[S_CUR_CNT])    cur_cnt <= wdata;
      else if (reload_ev)       cur_cnt <= nxt_cnt;
      else if (strobe)          cur_cnt <= (cur_cnt == '0) ? '0 : cur_cnt - ONE_V;

      if (wr_sel[S_NXT_ADDR])   nxt_addr <= wdata;
      if (wr_sel[S_NXT_CNT])    nxt_cnt  <= wdata;

      if (wr_sel[S_NXT_CNT])    dirty <= 1'b1;
      else if (reload_ev)       dirty <= 1'b0;
    end
  end
endmodule

// File: rtl/adma_csr.sv
module adma_csr #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [1:0]        reload_ev,
  input  logic [1:0]        stop_ev,
  input  logic              drop_ev,
  input  logic              err_evt,
  input  logic [1:0]        dirty,
  output logic [DATA_W-1:0] csr_word,
  output logic [1:0]        go,
  output logic [1:0]        pause,
  output logic              codec_rst,
  output logic              soft_rst,
  output logic              clr,
  output logic              irq
);
  import adma_pkg::*;

  localparam logic [DATA_W-1:0] MASK_W = DATA_W'(CTRL_MASK);

  logic [DATA_W-1:0] ctrl_q, ctrl_d;
  logic pflag, cflag, eflag, pufl, cufl, pempty, cdrop;
  logic summary, irq_d;

  function automatic logic w1(input logic wr_i, input logic [DATA_W-1:0] d, input int b);
    return wr_i && d[b];
  endfunction

  always_comb begin
    clr    = soft_rst || (wr && wdata[B_SRST]);
    ctrl_d = wr ? (wdata & MASK_W) : ctrl_q;
    if (stop_ev[CH_CAP])  ctrl_d[B_CRUN] = 1'b0;
    if (stop_ev[CH_PLAY]) ctrl_d[B_PRUN] = 1'b0;
  end

  always_comb begin
    summary = (pflag && ctrl_q[B_PIE]) || (cflag && ctrl_q[B_CIE]) ||
              (eflag && ctrl_q[B_EIE]) || (pufl && ctrl_q[B_PUIE]) ||
              (cufl && ctrl_q[B_CUIE]);
    irq_d   = ctrl_q[B_GIE] && summary;
  end

  always_comb begin
    csr_word          = ctrl_q;
    csr_word[B_SUM]   = summary;
    csr_word[B_PFLAG] = pflag;
    csr_word[B_CFLAG] = cflag;
    csr_word[B_EFLAG] = eflag;
    csr_word[B_PUFL]  = pufl;
    csr_word[B_PEMPT] = pempty;
    csr_word[B_PDIRT] = dirty[CH_PLAY];
    csr_word[B_CDROP] = cdrop;
    csr_word[B_CDIRT] = dirty[CH_CAP];
    csr_word[B_CUFL]  = cufl;
    csr_word[B_SRST]  = soft_rst;
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      ctrl_q   <= '0;
      pflag    <= 1'b0;
      cflag    <= 1'b0;
      eflag    <= 1'b0;
      pufl     <= 1'b0;
      cufl     <= 1'b0;
      pempty   <= 1'b0;
      cdrop    <= 1'b0;
      irq      <= 1'b0;
      soft_rst <= !rst && !soft_rst;
    end else begin
      ctrl_q <= ctrl_d;
      pflag  <= (pflag && !w1(wr, wdata, B_PFLAG)) || reload_ev[CH_PLAY];
      cflag  <= (cflag && !w1(wr, wdata, B_CFLAG)) || reload_ev[CH_CAP];
      eflag  <= (eflag && !w1(wr, wdata, B_EFLAG)) || err_evt;
      pufl   <= (pufl  && !w1(wr, wdata, B_PUFL))  || stop_ev[CH_PLAY];
      cufl   <= (cufl  && !w1(wr, wdata, B_CUFL))  || stop_ev[CH_CAP];
      pempty <= pempty || stop_ev[CH_PLAY];
      cdrop  <= cdrop || stop_ev[CH_CAP] || drop_ev;
      irq    <= irq_d;
    end
  end

  assign go        = {ctrl_q[B_PRUN], ctrl_q[B_CRUN]};
  assign pause     = {ctrl_q[B_PPAUS], ctrl_q[B_CPAUS]};
  assign codec_rst = ctrl_q[B_CODEC];
endmodule

// File: rtl/adma_rdmux.sv
module adma_rdmux #(
  parameter int DATA_W = 32,
  parameter int IDX_W  = 4,
  parameter int NWORDS = 8
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [IDX_W-1:0]         idx,
  input  logic                     aligned,
  input  logic [DATA_W-1:0]        csr_word,
  input  logic [NWORDS*DATA_W-1:0] chan_words,
  output logic [DATA_W-1:0]        rdata
);
  import adma_pkg::*;

  logic [DATA_W-1:0] sel;

  always_comb begin
    sel = '0;
    if (aligned) begin
      if (int'(idx) == W_CSR) sel = csr_word;
      else if (int'(idx) >= W_CHAN0 && int'(idx) < W_CHAN0 + NWORDS)
        sel = chan_words[(int'(idx) - W_CHAN0)*DATA_W +: DATA_W];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= sel;
  end
endmodule

// File: rtl/audio_dma_regs.sv
module audio_dma_regs #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 6,
  parameter int STEP   = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              cap_xfer,
  input  logic              play_xfer,
  input  logic              err_evt,
  output logic [DATA_W-1:0] cap_addr,
  output logic [DATA_W-1:0] play_addr,
  output logic              cap_run,
  output logic              play_run,
  output logic              codec_rst,
  output logic              irq
);
  import adma_pkg::*;

  localparam int IDX_W  = ADDR_W - 2;
  localparam int NWORDS = NUM_CH * W_SPAN;

  logic [IDX_W-1:0]         idx;
  logic                     aligned;
  logic                     wr_ok;
  logic [DATA_W-1:0]        csr_word;
  logic [1:0]               go, pause, xfer, dirty, reload_ev, stop_ev, drop_v;
  logic                     soft_rst, clr;
  logic [NWORDS*DATA_W-1:0] chan_words;
  logic [DATA_W-1:0]        cur_addr_v [NUM_CH];
  logic [DATA_W-1:0]        cur_cnt_v  [NUM_CH];

  assign idx     = bus_addr[ADDR_W-1:2];
  assign aligned = (bus_addr[1:0] == 2'b00);
  assign wr_ok   = bus_wr && aligned;
  assign xfer    = {play_xfer, cap_xfer};

  adma_csr #(.DATA_W(DATA_W)) u_csr (
    .clk(clk), .rst(rst), .wr(wr_ok && int'(idx) == W_CSR), .wdata(bus_wdata),
    .reload_ev(reload_ev), .stop_ev(stop_ev), .drop_ev(drop_v[CH_CAP]),
    .err_evt(err_evt), .dirty(dirty), .csr_word(csr_word), .go(go),
    .pause(pause), .codec_rst(codec_rst), .soft_rst(soft_rst), .clr(clr),
    .irq(irq)
  );

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    localparam int BASE = W_CHAN0 + g * W_SPAN;
    logic [3:0]        sel;
    logic [DATA_W-1:0] ca, cc, na, nc;

    for (genvar s = 0; s < W_SPAN; s++) begin : g_sel
      assign sel[s] = wr_ok && (int'(idx) == BASE + s);
    end

    adma_channel #(.DATA_W(DATA_W), .STEP(STEP), .DROP_IDLE(g == CH_CAP)) u_ch (
      .clk(clk), .rst(rst), .clr(clr), .go(go[g]), .pause(pause[g]),
      .xfer(xfer[g]), .wr_sel(sel), .wdata(bus_wdata),
      .cur_addr(ca), .cur_cnt(cc), .nxt_addr(na), .nxt_cnt(nc),
      .dirty(dirty[g]), .reload_ev(reload_ev[g]), .stop_ev(stop_ev[g]),
      .drop_ev(drop_v[g])
    );

    assign chan_words[(g*W_SPAN + S_CUR_ADDR)*DATA_W +: DATA_W] = ca;
    assign chan_words[(g*W_SPAN + S_CUR_CNT)*DATA_W +: DATA_W]  = cc;
    assign chan_words[(g*W_SPAN + S_NXT_ADDR)*DATA_W +: DATA_W] = na;
    assign chan_words[(g*W_SPAN + S_NXT_CNT)*DATA_W +: DATA_W]  = nc;
    assign cur_addr_v[g] = ca;
    assign cur_cnt_v[g]  = cc;
  end

  adma_rdmux #(.DATA_W(DATA_W), .IDX_W(IDX_W), .NWORDS(NWORDS)) u_rd (
    .clk(clk), .rst(rst), .idx(idx), .aligned(aligned), .csr_word(csr_word),
    .chan_words(chan_words), .rdata(bus_rdata)
  );

  assign cap_addr  = cur_addr_v[CH_CAP];
  assign play_addr = cur_addr_v[CH_PLAY];
  assign cap_run   = go[CH_CAP] && !pause[CH_CAP];
  assign play_run  = go[CH_PLAY] && !pause[CH_PLAY];

  logic [DATA_W-1:0] cap_cnt_o;
  logic              cap_dirty_o, cap_go_o, cap_pause_o;
  assign cap_cnt_o   = cur_cnt_v[CH_CAP];
  assign cap_dirty_o = dirty[CH_CAP];
  assign cap_go_o    = go[CH_CAP];
  assign cap_pause_o = pause[CH_CAP];
endmodule

// File: rtl/adma_chk.sv
module adma_chk #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              wr,
  input logic              soft_rst,
  input logic              cap_xfer,
  input logic              cap_go,
  input logic              cap_pause,
  input logic              cap_dirty,
  input logic [DATA_W-1:0] cap_cnt,
  input logic [DATA_W-1:0] cap_addr,
  input logic [DATA_W-1:0] csr_word,
  input logic              irq
);
  // R13
  srst_selfclear_chk: assert property (@(posedge clk) disable iff (rst)
    soft_rst |=> !soft_rst);

  // R13
  srst_zero_chk: assert property (@(posedge clk) disable iff (rst)
    soft_rst |-> (cap_cnt == '0 && cap_addr == '0 && csr_word == DATA_W'(1)));

  // R9
  pause_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (cap_pause && !wr) |=> ($stable(cap_cnt) && $stable(cap_addr)));

  // R5
  dirty_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (cap_dirty && !wr && !cap_xfer) |=> cap_dirty);

  // R4
  count_step_chk: assert property (@(posedge clk) disable iff (rst)
    (cap_go && !cap_pause && cap_xfer && cap_cnt > DATA_W'(1) && !wr && !soft_rst)
      |=> cap_cnt == $past(cap_cnt) - DATA_W'(1));

  // R12
  irq_gate_chk: assert property (@(posedge clk) disable iff (rst)
    !soft_rst |=> irq == ($past(csr_word[19]) && $past(csr_word[23])));
endmodule

bind audio_dma_regs adma_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .wr(bus_wr), .soft_rst(soft_rst), .cap_xfer(cap_xfer),
  .cap_go(cap_go_o), .cap_pause(cap_pause_o), .cap_dirty(cap_dirty_o),
  .cap_cnt(cap_cnt_o), .cap_addr(cap_addr), .csr_word(csr_word), .irq(irq)
);

// File: tb/tb_audio_dma_regs.sv
`timescale 1ns/1ps
module tb_audio_dma_regs;
  localparam int DW = 32;
  localparam int AW = 6;

  logic          clk = 1'b0;
  logic          rst;
  logic          bus_wr;
  logic [AW-1:0] bus_addr;
  logic [DW-1:0] bus_wdata;
  logic [DW-1:0] bus_rdata;
  logic          cap_xfer, play_xfer, err_evt;
  logic [DW-1:0] cap_addr, play_addr;
  logic          cap_run, play_run, codec_rst, irq;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  audio_dma_regs #(.DATA_W(DW), .ADDR_W(AW), .STEP(4)) dut (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cap_xfer(cap_xfer),
    .play_xfer(play_xfer), .err_evt(err_evt), .cap_addr(cap_addr),
    .play_addr(play_addr), .cap_run(cap_run), .play_run(play_run),
    .codec_rst(codec_rst), .irq(irq)
  );

  task automatic check(input string req, input logic [DW-1:0] got, input logic [DW-1:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%h expected=%h", req, got, exp);
    end
  endtask

  // all tasks start and end at a falling edge
  task automatic wr(input int a, input logic [DW-1:0] d);
    bus_wr = 1'b1; bus_addr = AW'(a); bus_wdata = d;
    @(posedge clk); @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd_chk(input string req, input int a, input logic [DW-1:0] exp);
    bus_addr = AW'(a);
    @(posedge clk); @(negedge clk);
    check(req, bus_rdata, exp);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin @(posedge clk); @(negedge clk); end
  endtask

  task automatic pulse_cap();
    cap_xfer = 1'b1; @(posedge clk); @(negedge clk); cap_xfer = 1'b0;
  endtask

  task automatic pulse_play();
    play_xfer = 1'b1; @(posedge clk); @(negedge clk); play_xfer = 1'b0;
  endtask

  task automatic pulse_err();
    err_evt = 1'b1; @(posedge clk); @(negedge clk); err_evt = 1'b0;
  endtask

  task automatic t_reset();
    for (int a = 0; a < 48; a += 4) rd_chk("R1 reset read", a, '0);
    check("R1 irq", DW'(irq), '0);
  endtask

  task automatic t_regs();
    for (int k = 0; k < 8; k++) wr(16 + 4*k, 32'hA000_0000 + DW'(k*16 + 3));
    for (int k = 0; k < 8; k++) rd_chk("R2 readback", 16 + 4*k, 32'hA000_0000 + DW'(k*16 + 3));
    wr(4, 32'hFFFF_FFFF); wr(8, 32'h1234_5678); wr(12, 32'hDEAD_BEEF);
    rd_chk("R2 pad 4", 4, '0);
    rd_chk("R2 pad 12", 12, '0);
    wr(17, 32'h5555_5555);
    rd_chk("R2 unaligned write ignored", 16, 32'hA000_0003);
    rd_chk("R2 unaligned read", 17, '0);
  endtask

  task automatic t_softrst();
    wr(0, 32'h1);
    rd_chk("R13 reset bit visible", 0, 32'h1);
    rd_chk("R13 reset bit cleared", 0, 32'h0);
    for (int k = 0; k < 8; k++) rd_chk("R13 regs cleared", 16 + 4*k, '0);
  endtask

  task automatic t_ctrl();
    wr(0, 32'h000F_11EC);
    rd_chk("R3 control readback", 0, 32'h000F_11EC);
    check("R3 codec_rst", DW'(codec_rst), 1);
    check("R3 cap_run paused", DW'(cap_run), 0);
    wr(0, 32'h0);
    check("R3 codec_rst low", DW'(codec_rst), 0);
  endtask

  task automatic t_xfer();
    wr(16, 32'h1000); wr(20, 3); wr(0, 32'h4);
    check("R4 cap_run", DW'(cap_run), 1);
    pulse_cap();
    rd_chk("R4 addr step", 16, 32'h1004);
    rd_chk("R4 count step", 20, 2);
    check("R4 cap_addr port", cap_addr, 32'h1004);
    check("R4 playback untouched", play_addr, 0);
  endtask

  task automatic t_chain();
    wr(24, 32'h2000); wr(28, 5);
    rd_chk("R5 capture dirty", 0, 32'h0000_0404);
    pulse_cap();
    rd_chk("R6 pre-chain count", 20, 1);
    pulse_cap();
    rd_chk("R6 chained addr", 16, 32'h2000);
    rd_chk("R6 chained count", 20, 5);
    rd_chk("R6 flag set dirty clear", 0, 32'h0020_0004);
    check("R6 cap_addr port", cap_addr, 32'h2000);
  endtask

  task automatic t_w1c();
    wr(0, 32'h4);
    rd_chk("R10 write 0 keeps flag", 0, 32'h0020_0004);
    wr(0, 32'h0020_0004);
    rd_chk("R10 write 1 clears flag", 0, 32'h4);
  endtask

  task automatic t_stop();
    wr(32, 32'h3000); wr(36, 1); wr(0, 32'hC);
    pulse_play();
    rd_chk("R7 playback stop status", 0, 32'h0000_C004);
    rd_chk("R7 playback addr", 32, 32'h3004);
    rd_chk("R7 playback count", 36, 0);
    check("R7 play_run", DW'(play_run), 0);
    wr(20, 1);
    pulse_cap();
    rd_chk("R7 capture stop status", 0, 32'h0000_CA00);
    rd_chk("R7 capture addr", 16, 32'h2004);
  endtask

  task automatic t_pause();
    wr(32, 32'h5000); wr(36, 4); wr(0, 32'h88);
    check("R9 play_run paused", DW'(play_run), 0);
    pulse_play(); pulse_play();
    rd_chk("R9 paused addr", 32, 32'h5000);
    rd_chk("R9 paused count", 36, 4);
    wr(0, 32'h8);
    pulse_play();
    rd_chk("R9 resumed addr", 32, 32'h5004);
    rd_chk("R9 resumed count", 36, 3);
    rd_chk("R9 status", 0, 32'h0000_CA08);
  endtask

  task automatic t_irq();
    pulse_err();
    rd_chk("R11 error flag", 0, 32'h0010_CA08);
    check("R12 irq off without enable", DW'(irq), 0);
    wr(0, 32'h0009_0008);
    rd_chk("R12 summary error", 0, 32'h0099_CA08);
    idle(1);
    check("R12 irq error", DW'(irq), 1);
    wr(0, 32'h0019_0008);
    rd_chk("R12 error cleared", 0, 32'h0009_CA08);
    idle(1);
    check("R12 irq dropped", DW'(irq), 0);
    wr(0, 32'h0009_1008);
    rd_chk("R12 summary underrun", 0, 32'h0089_DA08);
    idle(1);
    check("R12 irq underrun", DW'(irq), 1);
    wr(0, 32'h0001_1008);
    rd_chk("R12 global enable off", 0, 32'h0081_DA08);
    idle(1);
    check("R12 irq gated", DW'(irq), 0);
  endtask

  task automatic t_drop();
    wr(0, 32'h1); idle(1);
    wr(0, 32'h40);
    pulse_cap();
    rd_chk("R8 paused idle no drop", 0, 32'h40);
    wr(0, 32'h0);
    pulse_cap();
    rd_chk("R8 idle drop", 0, 32'h800);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog got=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
    cap_xfer = 1'b0; play_xfer = 1'b0; err_evt = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    t_reset();
    t_regs();
    t_softrst();
    t_ctrl();
    t_xfer();
    t_chain();
    t_w1c();
    t_stop();
    t_pause();
    t_irq();
    t_drop();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule